// File: doc/BRIEF.md
# Quadratic-Extension Multiply and Square Unit

The unit performs arithmetic in the quadratic extension of a prime field. It uses the polynomial i^2 + 1, so elements are pairs (x0, x1) that stand for x0 + x1·i. The prime p is a parameter and must satisfy p ≡ 3 mod 4. Under that condition -1 is not a square, and each i^2 term folds back as a plain field subtraction.

A caller presents two elements a and b and an opcode, then pulses `start`. The operands are captured on the accepting edge. For a product, the unit takes three base-field multiplications in the Karatsuba arrangement. For a square, it takes two multiplications in the complex-squaring arrangement. Each multiplication goes through a pipelined behavioural modular multiplier, with modular adders and subtractors around it.

Completion always arrives after a fixed number of cycles: 36 for a product and 39 for a square. A fixed count lets an outer scheduler plan around the unit without handshaking. The result stays on the outputs until the next completion.

Top module: `fp2_mulsq_unit`

## Requirements
- R1: With `op`=0 (multiply), the results are c0 = a0·b0 − a1·b1 mod p and c1 = a0·b1 + a1·b0 mod p.
- R2: With `op`=1 (square), the results are c0 = a0² − a1² mod p and c1 = 2·a0·a1 mod p, and the values on b0 and b1 have no effect on either result.
- R3: For operands in [0, p), both results lie in [0, p), including when every operand equals p−1.
- R4: For a multiply, `done` is high in the cycle that follows the 36th rising edge after the edge that accepted `start`.
- R5: For a square, `done` is high in the cycle that follows the 39th rising edge after the accepting edge.
- R6: `done` is high for exactly one cycle, and exactly once for each accepted `start`.
- R7: A `start` seen while an operation is in progress is ignored. It produces no extra `done` and does not alter the result of the operation in flight.
- R8: c0 and c1 change only in a cycle in which `done` is high, and otherwise hold the last result.
- R9: While reset is held, and after it is released, `done` is low and c0 and c1 are zero until the first completion.
- R10: A `start` presented during the cycle in which `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start | input | 1 | Request; accepted when the unit is idle |
| op | input | 1 | 0 = multiply a·b, 1 = square a² |
| a0 | input | W | Real part of a, in [0, p) |
| a1 | input | W | Imaginary part of a, in [0, p) |
| b0 | input | W | Real part of b, in [0, p); unused for square |
| b1 | input | W | Imaginary part of b, in [0, p); unused for square |
| done | output | 1 | One-cycle completion pulse |
| c0 | output | W | Real part of the result |
| c1 | output | W | Imaginary part of the result |

## Verification
The hardest case to reach is a second `start` arriving while products are still moving through the multiplier pipeline. If that request were taken, it would overwrite the latched operands and corrupt the intermediate products. The stimulus reaches this case by raising `start` a few cycles into a multiply, with different operands and the square opcode. The bench then checks that only one completion appears, that it carries the first operation's answer, and that the held outputs have not moved fifty cycles later. A second hard case is a request placed in the completion cycle itself. The driver reaches it by issuing chained operations in that cycle and measuring each latency from its own accepting edge.

// File: rtl/fp2_pkg.sv
package fp2_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_SQR = 1'b1
  } fp2_op_e;

  // three multiplier issue slots per operation at most
  localparam int NSLOT = 3;
  localparam int TAG_W = 2;

endpackage

// File: rtl/fp_addsub.sv
// Modular add or subtract of two reduced residues, one conditional correction.
module fp_addsub #(
  parameter int          W = 16,
  parameter int unsigned P = 65519
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] z
);

  localparam logic [W:0] PX = (W+1)'(P);

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  always_comb begin
    sum_w = {1'b0, x} + {1'b0, y};
    dif_w = {1'b0, x} - {1'b0, y};
    if (sub) begin
      // borrow means x < y: wrap once by adding p
      if (x < y) z = W'(dif_w + PX);
      else       z = W'(dif_w);
    end else begin
      if (sum_w >= PX) z = W'(sum_w - PX);
      else             z = W'(sum_w);
    end
  end

endmodule

// File: rtl/fp_mul_pipe.sv
// Behavioural pipelined modular multiplier, LAT register stages.
module fp_mul_pipe #(
  parameter int          W     = 16,
  parameter int unsigned P     = 65519,
  parameter int          LAT   = 4,
  parameter int          TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  output logic             out_vld,
  output logic [TAG_W-1:0] out_tag,
  output logic [W-1:0]     out_res
);

  localparam logic [2*W-1:0] PW = (2*W)'(P);

  logic [2*W-1:0] prod_w;
  logic [W-1:0]   red_w;

  logic [LAT-1:0]            vld_q;
  logic [LAT-1:0][TAG_W-1:0] tag_q;
  logic [LAT-1:0][W-1:0]     res_q;

  always_comb begin
    prod_w = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    red_w  = W'(prod_w % PW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      res_q <= '0;
    end else begin
      vld_q[0] <= in_vld;
      if (in_vld) begin
        tag_q[0] <= in_tag;
        res_q[0] <= red_w;
      end
      for (int i = LAT-1; i > 0; i--) begin
        vld_q[i] <= vld_q[i-1];
        if (vld_q[i-1]) begin
          tag_q[i] <= tag_q[i-1];
          res_q[i] <= res_q[i-1];
        end
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_tag = tag_q[LAT-1];
  assign out_res = res_q[LAT-1];

endmodule

// File: rtl/fp2_seq.sv
// Operation sequencer: fixed-length count per opcode, issue slots, completion.
module fp2_seq
  import fp2_pkg::*;
#(
  parameter int MUL_CYCLES = 36,
  parameter int SQR_CYCLES = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op,
  output logic             accept,
  output logic             busy,
  output fp2_op_e          op_q,
  output logic [TAG_W-1:0] slot,
  output logic             issue,
  output logic             finish,
  output logic             done
);

  localparam int TOT_MAX = (MUL_CYCLES > SQR_CYCLES) ? MUL_CYCLES : SQR_CYCLES;
  localparam int CW      = $clog2(TOT_MAX + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  fp2_op_e       op_d;
  logic          done_q, done_d;
  logic [CW-1:0] last_w;
  logic [CW-1:0] nslot_w;

  always_comb begin
    last_w  = (op_q == OP_SQR) ? CW'(SQR_CYCLES - 1) : CW'(MUL_CYCLES - 1);
    nslot_w = (op_q == OP_SQR) ? CW'(2) : CW'(NSLOT);
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        op_d   = fp2_op_e'(op);
      end
    end else if (cnt_q == last_w) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      done_q <= done_d;
    end
  end

  assign accept = !busy_q && start;
  assign busy   = busy_q;
  assign slot   = cnt_q[TAG_W-1:0];
  assign issue  = busy_q && (cnt_q < nslot_w);
  assign finish = busy_q && (cnt_q == last_w);
  assign done   = done_q;

endmodule

// File: rtl/fp2_mulsq_unit.sv
module fp2_mulsq_unit
  import fp2_pkg::*;
#(
  parameter int          W          = 16,
  parameter int unsigned P          = 65519,
  parameter int          MUL_LAT    = 4,
  parameter int          MUL_CYCLES = 36,
  parameter int          SQR_CYCLES = 39
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op,
  input  logic [W-1:0] a0,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] b0,
  input  logic [W-1:0] b1,
  output logic         done,
  output logic [W-1:0] c0,
  output logic [W-1:0] c1
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // sequencer
  logic             accept;
  logic             busy;
  fp2_op_e          op_q;
  logic [TAG_W-1:0] slot;
  logic             issue;
  logic             finish;

  fp2_seq #(
    .MUL_CYCLES(MUL_CYCLES),
    .SQR_CYCLES(SQR_CYCLES)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_ni),
    .start (start),
    .op    (op),
    .accept(accept),
    .busy  (busy),
    .op_q  (op_q),
    .slot  (slot),
    .issue (issue),
    .finish(finish),
    .done  (done)
  );

  // operand capture
  logic [W-1:0] a0_q, a1_q, b0_q, b1_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a0_q <= '0;
      a1_q <= '0;
      b0_q <= '0;
      b1_q <= '0;
    end else if (accept) begin
      a0_q <= a0;
      a1_q <= a1;
      b0_q <= b0;
      b1_q <= b1;
    end
  end

  // pre-combination: a0+a1, and b0+b1 (multiply) or a0-a1 (square)
  logic         is_sqr;
  logic [W-1:0] pre_a;
  logic [W-1:0] pre_b;
  logic [W-1:0] pb_x, pb_y;

  assign is_sqr = (op_q == OP_SQR);
  assign pb_x   = is_sqr ? a0_q : b0_q;
  assign pb_y   = is_sqr ? a1_q : b1_q;

  fp_addsub #(.W(W), .P(P)) u_pre_a (
    .x(a0_q), .y(a1_q), .sub(1'b0), .z(pre_a)
  );

  fp_addsub #(.W(W), .P(P)) u_pre_b (
    .x(pb_x), .y(pb_y), .sub(is_sqr), .z(pre_b)
  );

  // multiplier operand selection per issue slot
  logic [W-1:0] mx, my;

  always_comb begin
    case (slot)
      TAG_W'(0): begin
        mx = a0_q;
        my = is_sqr ? a1_q : b0_q;
      end
      TAG_W'(1): begin
        mx = is_sqr ? pre_a : a1_q;
        my = is_sqr ? pre_b : b1_q;
      end
      default: begin
        mx = pre_a;
        my = pre_b;
      end
    endcase
  end

  logic             mul_vld;
  logic [TAG_W-1:0] mul_tag;
  logic [W-1:0]     mul_res;

  fp_mul_pipe #(
    .W    (W),
    .P    (P),
    .LAT  (MUL_LAT),
    .TAG_W(TAG_W)
  ) u_mul (
    .clk    (clk),
    .rst_n  (rst_ni),
    .in_vld (issue),
    .in_tag (slot),
    .x      (mx),
    .y      (my),
    .out_vld(mul_vld),
    .out_tag(mul_tag),
    .out_res(mul_res)
  );

  // product registers, one per slot
  logic [NSLOT-1:0][W-1:0] prod_v;

  for (genvar g = 0; g < NSLOT; g++) begin : g_prod
    logic [W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                               val_q <= '0;
      else if (mul_vld && mul_tag == TAG_W'(g))  val_q <= mul_res;
    end
    assign prod_v[g] = val_q;
  end

  // post-combination
  //  multiply: c0 = v0 - v1 ; c1 = (v2 - v0) - v1
  //  square  : c0 = v1 + 0  ; c1 = (v0 + v0) - 0
  logic [W-1:0] p0_x, p0_y, p1_x, p2_y;
  logic [W-1:0] c0_nx, mid_w, c1_nx;

  assign p0_x = is_sqr ? prod_v[1] : prod_v[0];
  assign p0_y = is_sqr ? '0        : prod_v[1];
  assign p1_x = is_sqr ? prod_v[0] : prod_v[2];
  assign p2_y = is_sqr ? '0        : prod_v[1];

  fp_addsub #(.W(W), .P(P)) u_post_c0 (
    .x(p0_x), .y(p0_y), .sub(!is_sqr), .z(c0_nx)
  );

  fp_addsub #(.W(W), .P(P)) u_post_mid (
    .x(p1_x), .y(prod_v[0]), .sub(!is_sqr), .z(mid_w)
  );

  fp_addsub #(.W(W), .P(P)) u_post_c1 (
    .x(mid_w), .y(p2_y), .sub(1'b1), .z(c1_nx)
  );

  // result registers
  logic [W-1:0] c0_q, c1_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      c0_q <= '0;
      c1_q <= '0;
    end else if (finish) begin
      c0_q <= c0_nx;
      c1_q <= c1_nx;
    end
  end

  assign c0 = c0_q;
  assign c1 = c1_q;

endmodule

// File: rtl/fp2_mulsq_chk.sv
module fp2_mulsq_chk #(
  parameter int          W          = 16,
  parameter int unsigned P          = 65519,
  parameter int          MUL_CYCLES = 36,
  parameter int          SQR_CYCLES = 39
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         op,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] c0,
  input logic [W-1:0] c1
);

  localparam int TOT_MAX = (MUL_CYCLES > SQR_CYCLES) ? MUL_CYCLES : SQR_CYCLES;
  localparam int CW      = $clog2(TOT_MAX + 2);
  localparam logic [W:0] PX = (W+1)'(P);

  logic          run_q;
  logic          opk_q;
  logic [CW-1:0] age_q;

  // independent age counter from the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      opk_q <= 1'b0;
      age_q <= '0;
    end else if (start && !busy) begin
      run_q <= 1'b1;
      opk_q <= op;
      age_q <= '0;
    end else begin
      if (done)       run_q <= 1'b0;
      if (run_q)      age_q <= age_q + CW'(1);
    end
  end

  a_r4_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !opk_q) |-> (age_q == CW'(MUL_CYCLES)));

  a_r5_sqr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && opk_q) |-> (age_q == CW'(SQR_CYCLES)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_owned: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_q);

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (({1'b0, c0} < PX) && ({1'b0, c1} < PX)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(c0) && $stable(c1)));

endmodule

bind fp2_mulsq_unit fp2_mulsq_chk #(
  .W         (W),
  .P         (P),
  .MUL_CYCLES(MUL_CYCLES),
  .SQR_CYCLES(SQR_CYCLES)
) u_chk (
  .clk  (clk),
  .rst_n(rst_ni),
  .start(start),
  .op   (op),
  .busy (busy),
  .done (done),
  .c0   (c0),
  .c1   (c1)
);

// File: tb/fp2_mulsq_unit_bench.sv
module fp2_mulsq_unit_bench;

  localparam int          W    = 16;
  localparam int unsigned P    = 65519;
  localparam int          MULC = 36;
  localparam int          SQRC = 39;
  localparam int          WDOG = 150000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         op;
  logic [W-1:0] a0, a1, b0, b1;
  logic         done;
  logic [W-1:0] c0, c1;

  fp2_mulsq_unit #(.W(W), .P(P)) u_fp2_mulsq_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .a0(a0), .a1(a1), .b0(b0), .b1(b1),
    .done(done), .c0(c0), .c1(c1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks   = 0;
  int  failures = 0;
  int  issued   = 0;
  int  seen     = 0;
  bit  ended    = 0;
  bit  prev_done = 0;
  longint unsigned last_c0 = 0, last_c1 = 0;

  typedef struct {
    longint unsigned e0;
    longint unsigned e1;
    int              lat;
    int              acc;
    string           ftag;
    string           ltag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic void model(input bit sq,
                                input longint unsigned x0, x1, y0, y1,
                                output longint unsigned e0, e1);
    if (!sq) begin
      e0 = ((x0 * y0) % P + P - (x1 * y1) % P) % P;
      e1 = ((x0 * y1) % P + (x1 * y0) % P) % P;
    end else begin
      e0 = ((x0 * x0) % P + P - (x1 * x1) % P) % P;
      e1 = (2 * ((x0 * x1) % P)) % P;
    end
  endfunction

  // driver: called at a falling edge; start is taken on the next rising edge
  task automatic issue(input bit sq, input logic [W-1:0] x0, x1, y0, y1);
    exp_t it;
    longint unsigned e0, e1;
    model(sq, x0, x1, y0, y1, e0, e1);
    start = 1'b1; op = sq;
    a0 = x0; a1 = x1; b0 = y0; b1 = y1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs after acceptance: operands must already be latched
    a0 = ~x0; a1 = ~x1; b0 = ~y0; b1 = ~y1; op = ~sq;
    it.e0 = e0; it.e1 = e1;
    it.lat  = sq ? SQRC : MULC;
    it.acc  = cyc;
    it.ftag = sq ? "R2" : "R1";
    it.ltag = sq ? "R5" : "R4";
    sb.push_back(it);
    issued++;
  endtask

  task automatic wait_done(input string req);
    bit got = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    if (!got) chk(1'b0, req, "no completion within window", 0, 1);
  endtask

  task automatic run_one(input bit sq, input logic [W-1:0] x0, x1, y0, y1);
    issue(sq, x0, x1, y0, y1);
    wait_done("R6");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (done) begin
      seen++;
      chk(!prev_done, "R6", "done longer than one cycle", 1, 0);
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "completion with no accepted request", 1, 0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        chk(c0 == W'(it.e0), it.ftag, "c0", c0, it.e0);
        chk(c1 == W'(it.e1), it.ftag, "c1", c1, it.e1);
        chk((c0 < P) && (c1 < P), "R3", "result range c0", c0, P - 1);
        chk(cyc - it.acc == it.lat, it.ltag, "latency", cyc - it.acc, it.lat);
        last_c0 <= it.e0;
        last_c1 <= it.e1;
      end
    end
    prev_done <= done;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > WDOG && !ended) begin
      failures++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 1'b0;
    a0 = '0; a1 = '0; b0 = '0; b1 = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9", "done in reset", done, 0);
    chk(c0 == '0 && c1 == '0, "R9", "c0 in reset", c0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    chk(c0 == '0 && c1 == '0, "R9", "c1 after reset", c1, 0);

    // corner operands (R1, R2, R3)
    run_one(1'b0, W'(P-1), W'(P-1), W'(P-1), W'(P-1));
    run_one(1'b0, 16'd0, 16'd0, 16'd5, 16'd7);
    run_one(1'b0, 16'd1, 16'd0, 16'd1234, 16'd4321);
    run_one(1'b0, 16'd0, 16'd1, 16'd0, 16'd1);           // i*i = -1
    run_one(1'b1, W'(P-1), W'(P-1), 16'hBEEF, 16'h1234); // c0 = 0, b ignored
    run_one(1'b1, 16'd3, 16'd5, 16'd0, 16'd0);
    run_one(1'b1, W'(P-1), 16'd1, 16'hFFFF, 16'hFFFF);
    run_one(1'b1, 16'd3, 16'd5, 16'd999, 16'd17);        // same a, other b: R2

    // R8: result holds after completion
    repeat (12) @(negedge clk);
    chk(c0 == W'(last_c0), "R8", "c0 held", c0, last_c0);
    chk(c1 == W'(last_c1), "R8", "c1 held", c1, last_c1);

    // R10: requests placed in the completion cycle
    run_one(1'b0, 16'd100, 16'd200, 16'd300, 16'd400);
    issue(1'b1, 16'd11, 16'd22, 16'd0, 16'd0);
    wait_done("R10");
    issue(1'b0, W'(P-2), 16'd9, 16'd8, W'(P-3));
    wait_done("R10");

    // R7: start during an operation is ignored
    issue(1'b0, 16'd2, 16'd3, 16'd4, 16'd5);
    repeat (4) @(negedge clk);
    start = 1'b1; op = 1'b1; a0 = 16'd777; a1 = 16'd888; b0 = 16'd1; b1 = 16'd2;
    @(negedge clk);
    start = 1'b0;
    wait_done("R7");
    repeat (50) @(negedge clk);
    chk(seen == issued, "R7", "completion count", seen, issued);
    chk(c0 == W'(P-7) && c1 == 16'd22, "R7", "c0 of first op", c0, P - 7);

    // random operands
    for (int n = 0; n < 30; n++) begin
      bit sq;
      sq = 1'($urandom);
      issue(sq, W'($urandom % P), W'($urandom % P),
                W'($urandom % P), W'($urandom % P));
      wait_done("R6");
    end

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R6", "outstanding expectations", sb.size(), 0);
    chk(seen == issued, "R6", "completions per accepted start", seen, issued);
    finish_run();
  end

endmodule